// File: doc/BRIEF.md
# Depth-Cascade Slice Token Controller

This block is the control logic for a single slice of a deeper FIFO built from several identical slices wired into a ring. Every slice sees the same clock, master reset, write and read enables, and shares one data-out bus. A write token and a read token circulate around the ring. Each slice passes a token on through its expansion output into the expansion input of the next slice, and the last slice feeds the first. A strap input picks the slice that holds both tokens when reset ends.

The slice holding the write token owns the writes. When its write address passes the last location it sends a one-cycle pulse on its write expansion output, and the next slice takes over. Reads rotate the same way. The slice drives the shared output bus only from its first accepted read while it holds the read token until the clock edge that follows its read handoff. During a program-register read, only the strapped first slice drives the bus. The storage array sits outside this block and uses the address and strobe outputs.

Top module: `cas_slice_ctrl`

## Requirements
- R1: When reset ends, a slice with `first_load_n` low holds both tokens (`wr_hold`=1, `rd_hold`=1). A slice with `first_load_n` high holds neither. On every slice, both expansion outputs and `bus_oe` are 0 and both addresses are 0.
- R2: `mem_we` is 1 in a cycle only when `wr_en` is 1 and the slice holds the write token. Write addresses run from 0 upward, one step per accepted write.
- R3: A write accepted at address DEPTH-1 makes `xout_wr` 1 for exactly the following cycle. The slice then gives up the write token, and its write address returns to 0.
- R4: While `xin_wr` is 1, the slice counts as the write-token holder for that cycle. It keeps the token in the cycles after that.
- R5: `mem_re` is 1 only when `rd_en` is 1, `prog_rd` is 0, the slice holds the read token (or `xin_rd` is 1), and the slice is not empty. Read addresses start at 0.
- R6: A read accepted at address DEPTH-1 makes `xout_rd` 1 for exactly the following cycle, and the slice gives up the read token.
- R7: `bus_oe` goes to 1 on the edge of an accepted read. It stays 1 through the cycle in which `xout_rd` is 1 and drops on the next edge, whatever `rd_en` is at that time.
- R8: A slice that holds the read token but has not yet made a read keeps `bus_oe` at 0.
- R9: While `prog_rd` is 1, a slice with `first_load_n` low drives the bus (`bus_oe`=1, `bus_prog_sel`=1). Any other slice keeps both outputs at 0. No read is accepted, and the read address does not move.
- R10: `slice_full` blocks writes and `slice_empty` blocks reads. A slice that has wrapped its write address but not yet its read address, with the two addresses equal, is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for writes and reads |
| rst_n | input | 1 | Master reset, active low, synchronous |
| first_load_n | input | 1 | Strap: low marks the slice that starts with both tokens |
| wr_en | input | 1 | Shared write enable |
| rd_en | input | 1 | Shared read enable |
| prog_rd | input | 1 | Program-register read in progress |
| xin_wr | input | 1 | Write-token expansion input from the previous slice |
| xin_rd | input | 1 | Read-token expansion input from the previous slice |
| xout_wr | output | 1 | Write-token handoff pulse to the next slice |
| xout_rd | output | 1 | Read-token handoff pulse to the next slice |
| mem_we | output | 1 | Write strobe to the local array |
| mem_waddr | output | $clog2(DEPTH) | Local write address |
| mem_re | output | 1 | Read strobe to the local array |
| mem_raddr | output | $clog2(DEPTH) | Local read address |
| bus_oe | output | 1 | Enable for the shared data-out drivers |
| bus_prog_sel | output | 1 | Put the program register on the bus instead of array data |
| wr_hold | output | 1 | Slice holds the write token this cycle |
| rd_hold | output | 1 | Slice holds the read token this cycle |
| slice_empty | output | 1 | Local array holds no unread word |
| slice_full | output | 1 | Local array has no free location |

## Verification
A table of mixed write/read patterns is run on the strapped slice with the ring left open. This lets the token leave for good, which separates accepted operations from operations the slice ignores once its token is gone. It also exposes the single-cycle width of each handoff pulse and the one-edge delay before the bus is released. A ring of one slice (output looped back to input) checks that a returning token is taken at once and that a fully wrapped slice reports full instead of empty. A non-first slice is fed external token pulses, which shows the token being taken in the pulse cycle and the bus staying undriven until its first read. Program reads are applied to both strap settings, which separates the first slice's bus ownership from the silence of the others.

// File: rtl/cas_pkg.sv
package cas_pkg;
  // True when a slot index is the final location of a slice of the given depth.
  function automatic logic at_last_slot(input int unsigned slot, input int unsigned depth);
    return slot == depth - 1;
  endfunction

  // Slot that follows the given one, wrapping to zero after the final location.
  function automatic int unsigned next_slot(input int unsigned slot, input int unsigned depth);
    return (slot == depth - 1) ? 0 : slot + 1;
  endfunction
endpackage

// File: rtl/cas_token_port.sv
// One side (write or read) of a slice: token flop, handoff pulse and wrapping pointer.
module cas_token_port #(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          first_load_n,
  input  logic          x_in,
  input  logic          op_req,
  input  logic          op_block,
  output logic          holding,
  output logic          op_fire,
  output logic          wrap_evt,
  output logic          tok_q,
  output logic          x_out,
  output logic [AW:0]   ptr
);
  logic [AW-1:0] slot;
  logic          last;

  assign slot     = ptr[AW-1:0];
  assign last     = cas_pkg::at_last_slot(32'(slot), DEPTH);
  assign holding  = tok_q | x_in;
  assign op_fire  = op_req & holding & ~op_block;
  assign wrap_evt = op_fire & last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tok_q <= ~first_load_n;
      x_out <= 1'b0;
      ptr   <= '0;
    end else begin
      x_out <= wrap_evt;
      if (wrap_evt)  tok_q <= 1'b0;
      else if (x_in) tok_q <= 1'b1;
      if (op_fire)
        ptr <= {ptr[AW] ^ last, AW'(cas_pkg::next_slot(32'(slot), DEPTH))};
    end
  end
endmodule

// File: rtl/cas_occupancy.sv
// Empty/full of the local array from the two wrap-extended pointers.
module cas_occupancy #(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic [AW:0] wptr,
  input  logic [AW:0] rptr,
  output logic        empty,
  output logic        full
);
  logic same_slot;
  assign same_slot = wptr[AW-1:0] == rptr[AW-1:0];
  assign empty     = same_slot & (wptr[AW] == rptr[AW]);
  assign full      = same_slot & (wptr[AW] != rptr[AW]);
endmodule

// File: rtl/cas_bus_gate.sv
// Output-driver ownership of the shared data bus.
module cas_bus_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic first_load_n,
  input  logic rd_fire,
  input  logic rd_handoff,
  input  logic prog_rd,
  output logic drv_q,
  output logic bus_oe,
  output logic bus_prog_sel
);
  always_ff @(posedge clk) begin
    if (!rst_n)          drv_q <= 1'b0;
    else if (rd_fire)    drv_q <= 1'b1;
    else if (rd_handoff) drv_q <= 1'b0;
  end

  assign bus_prog_sel = prog_rd & ~first_load_n;
  assign bus_oe       = prog_rd ? ~first_load_n : drv_q;
endmodule

// File: rtl/cas_slice_ctrl.sv
module cas_slice_ctrl #(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          first_load_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic          prog_rd,
  input  logic          xin_wr,
  input  logic          xin_rd,
  output logic          xout_wr,
  output logic          xout_rd,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic          mem_re,
  output logic [AW-1:0] mem_raddr,
  output logic          bus_oe,
  output logic          bus_prog_sel,
  output logic          wr_hold,
  output logic          rd_hold,
  output logic          slice_empty,
  output logic          slice_full
);
  // Named internal events, visible to the bound checker.
  logic          wr_fire, rd_fire, wr_wrap, rd_wrap;
  logic          wr_tok_q, rd_tok_q, drv_q;
  logic [AW:0]   wptr, rptr;

  cas_token_port #(.DEPTH(DEPTH)) u_wr (
    .clk(clk), .rst_n(rst_n), .first_load_n(first_load_n), .x_in(xin_wr),
    .op_req(wr_en), .op_block(slice_full), .holding(wr_hold), .op_fire(wr_fire),
    .wrap_evt(wr_wrap), .tok_q(wr_tok_q), .x_out(xout_wr), .ptr(wptr)
  );

  cas_token_port #(.DEPTH(DEPTH)) u_rd (
    .clk(clk), .rst_n(rst_n), .first_load_n(first_load_n), .x_in(xin_rd),
    .op_req(rd_en & ~prog_rd), .op_block(slice_empty), .holding(rd_hold),
    .op_fire(rd_fire), .wrap_evt(rd_wrap), .tok_q(rd_tok_q), .x_out(xout_rd),
    .ptr(rptr)
  );

  cas_occupancy #(.DEPTH(DEPTH)) u_occ (
    .wptr(wptr), .rptr(rptr), .empty(slice_empty), .full(slice_full)
  );

  cas_bus_gate u_bus (
    .clk(clk), .rst_n(rst_n), .first_load_n(first_load_n), .rd_fire(rd_fire),
    .rd_handoff(xout_rd), .prog_rd(prog_rd), .drv_q(drv_q), .bus_oe(bus_oe),
    .bus_prog_sel(bus_prog_sel)
  );

  assign mem_we    = wr_fire;
  assign mem_re    = rd_fire;
  assign mem_waddr = wptr[AW-1:0];
  assign mem_raddr = rptr[AW-1:0];
endmodule

// File: rtl/cas_slice_ctrl_chk.sv
module cas_slice_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic first_load_n,
  input logic prog_rd,
  input logic xin_wr,
  input logic mem_we,
  input logic mem_re,
  input logic xout_wr,
  input logic xout_rd,
  input logic wr_tok_q,
  input logic rd_tok_q,
  input logic wr_hold,
  input logic rd_hold,
  input logic bus_oe,
  input logic slice_full,
  input logic slice_empty
);
  p_we_token_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> wr_hold);
  p_re_token_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |-> (rd_hold && !prog_rd));
  p_xw_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    xout_wr |=> !xout_wr);
  p_xw_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    xout_wr |-> !wr_tok_q);
  p_xr_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    xout_rd |=> !xout_rd);
  p_xr_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    xout_rd |-> !rd_tok_q);
  p_xin_take_r4: assert property (@(posedge clk) disable iff (!rst_n)
    xin_wr |=> wr_tok_q);
  p_oe_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (xout_rd && !mem_re) |=> (prog_rd || !bus_oe));
  p_oe_after_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> (bus_oe || prog_rd));
  p_oe_waits_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_oe && !prog_rd && !mem_re) |=> (!bus_oe || prog_rd));
  p_prog_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_rd && first_load_n) |-> !bus_oe);
  p_no_write_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !slice_full);
  p_no_read_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |-> !slice_empty);
endmodule

bind cas_slice_ctrl cas_slice_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .first_load_n(first_load_n), .prog_rd(prog_rd),
  .xin_wr(xin_wr), .mem_we(mem_we), .mem_re(mem_re), .xout_wr(xout_wr),
  .xout_rd(xout_rd), .wr_tok_q(wr_tok_q), .rd_tok_q(rd_tok_q),
  .wr_hold(wr_hold), .rd_hold(rd_hold), .bus_oe(bus_oe),
  .slice_full(slice_full), .slice_empty(slice_empty)
);

// File: tb/cas_slice_ctrl_test.sv
`timescale 1ns/1ps
module cas_slice_ctrl_test;
  localparam int unsigned DEPTH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic first_load_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0, prog_rd = 1'b0;
  logic ext_xin_wr = 1'b0, ext_xin_rd = 1'b0, loop_mode = 1'b0;
  logic xin_wr, xin_rd, xout_wr, xout_rd, mem_we, mem_re;
  logic [1:0] mem_waddr, mem_raddr;
  logic bus_oe, bus_prog_sel, wr_hold, rd_hold, slice_empty, slice_full;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  assign xin_wr = loop_mode ? xout_wr : ext_xin_wr;
  assign xin_rd = loop_mode ? xout_rd : ext_xin_rd;

  always #2.5 clk = ~clk;

  cas_slice_ctrl #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .first_load_n(first_load_n), .wr_en(wr_en),
    .rd_en(rd_en), .prog_rd(prog_rd), .xin_wr(xin_wr), .xin_rd(xin_rd),
    .xout_wr(xout_wr), .xout_rd(xout_rd), .mem_we(mem_we), .mem_waddr(mem_waddr),
    .mem_re(mem_re), .mem_raddr(mem_raddr), .bus_oe(bus_oe),
    .bus_prog_sel(bus_prog_sel), .wr_hold(wr_hold), .rd_hold(rd_hold),
    .slice_empty(slice_empty), .slice_full(slice_full)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset(input logic strap, input logic loop);
    @(negedge clk);
    rst_n = 1'b0; first_load_n = strap; loop_mode = loop;
    wr_en = 0; rd_en = 0; prog_rd = 0; ext_xin_wr = 0; ext_xin_rd = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Vector bits: {wr_en, rd_en, exp_we, exp_re, exp_xout_wr, exp_xout_rd, exp_bus_oe}
  // The last three are sampled after the clock edge. Strapped slice, open ring, DEPTH 4.
  localparam logic [6:0] VEC [0:10] = '{
    7'b0100000, // read while empty: ignored
    7'b1010000, // write addr 0
    7'b1111001, // write addr 1 and read addr 0; bus driven after edge
    7'b1010001, // write addr 2
    7'b1010101, // write addr 3: wrap, write handoff pulse
    7'b1000001, // write token gone: ignored
    7'b0101001, // read addr 1
    7'b0101001, // read addr 2
    7'b0101011, // read addr 3: wrap, read handoff pulse, bus still driven
    7'b0000000, // bus released on the edge after the handoff
    7'b0100000  // read token gone: ignored
  };

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    // R1: reset state of the strapped slice
    do_reset(1'b0, 1'b0);
    chk("R1 wr_hold", wr_hold, 1);
    chk("R1 rd_hold", rd_hold, 1);
    chk("R1 bus_oe", bus_oe, 0);
    chk("R1 xout_wr", xout_wr, 0);
    chk("R1 xout_rd", xout_rd, 0);
    chk("R1 waddr", mem_waddr, 0);
    chk("R1 raddr", mem_raddr, 0);

    // Table walk: R2 R3 R5 R6 R7 R10
    for (int i = 0; i <= 10; i++) begin
      wr_en = VEC[i][6]; rd_en = VEC[i][5];
      #1;
      chk($sformatf("R2 we v%0d", i), mem_we, VEC[i][4]);
      chk($sformatf("R5 re v%0d", i), mem_re, VEC[i][3]);
      tick();
      chk($sformatf("R3 xout_wr v%0d", i), xout_wr, VEC[i][2]);
      chk($sformatf("R6 xout_rd v%0d", i), xout_rd, VEC[i][1]);
      chk($sformatf("R7 bus_oe v%0d", i), bus_oe, VEC[i][0]);
    end
    wr_en = 0; rd_en = 0;

    // Non-first slice: R1, R2, R4, R8
    do_reset(1'b1, 1'b0);
    chk("R1 other wr_hold", wr_hold, 0);
    chk("R1 other rd_hold", rd_hold, 0);
    wr_en = 1; #1;
    chk("R2 no token no write", mem_we, 0);
    ext_xin_wr = 1; #1;
    chk("R4 write in pulse cycle", mem_we, 1);
    chk("R4 first waddr", mem_waddr, 0);
    tick();
    ext_xin_wr = 0; wr_en = 0; #1;
    chk("R4 token kept", wr_hold, 1);
    ext_xin_rd = 1;
    tick();
    ext_xin_rd = 0; #1;
    chk("R8 read token kept", rd_hold, 1);
    chk("R8 bus idle before read", bus_oe, 0);
    rd_en = 1; #1;
    chk("R5 read by new holder", mem_re, 1);
    tick();
    rd_en = 0;
    chk("R7 bus after first read", bus_oe, 1);

    // Ring of one slice: R3, R4, R10
    do_reset(1'b0, 1'b1);
    for (int i = 0; i < 4; i++) begin
      wr_en = 1; #1;
      chk($sformatf("R2 loop write %0d", i), mem_we, 1);
      chk($sformatf("R2 loop waddr %0d", i), mem_waddr, i);
      tick();
    end
    #1;
    chk("R3 loop handoff", xout_wr, 1);
    chk("R3 waddr back to 0", mem_waddr, 0);
    chk("R4 token returns", wr_hold, 1);
    chk("R10 full", slice_full, 1);
    chk("R10 write blocked", mem_we, 0);
    wr_en = 0; rd_en = 1; #1;
    chk("R5 read from full", mem_re, 1);
    chk("R5 raddr 0", mem_raddr, 0);
    tick();
    rd_en = 0; wr_en = 1; #1;
    chk("R10 write after space", mem_we, 1);
    tick();
    wr_en = 0;

    // Program read: R9
    do_reset(1'b0, 1'b0);
    wr_en = 1;
    tick();
    wr_en = 0; prog_rd = 1; rd_en = 1; #1;
    chk("R9 no read in prog", mem_re, 0);
    chk("R9 first drives", bus_oe, 1);
    chk("R9 prog select", bus_prog_sel, 1);
    tick();
    prog_rd = 0; #1;
    chk("R9 raddr unmoved", mem_raddr, 0);
    chk("R9 read resumes", mem_re, 1);
    tick();
    rd_en = 0;
    do_reset(1'b1, 1'b0);
    prog_rd = 1; #1;
    chk("R9 other quiet", bus_oe, 0);
    chk("R9 other no select", bus_prog_sel, 0);
    prog_rd = 0;

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule